// File: doc/BRIEF.md
# Six-Channel Down-Counting Timer Bank

The block holds six independent 32-bit down-counters behind a small synchronous register port with a 10-bit byte address and a 32-bit data path. Each channel has a control word, an interval (reload) value and a live count. The control word picks one of four clock-enable sources and a power-of-two prescale, and it sets run, load-now and one-shot behaviour. The clock sources come into the block as single-cycle tick enables on the block clock.

When a running channel reaches zero on one of its prescaled ticks, it raises its status bit. A periodic channel then reloads from its interval value. A one-shot channel instead drops its own run bit. A shared interrupt-enable mask and a shared status register drive one interrupt line per channel. Software acknowledges an interrupt by writing ones to the status register. Two further words are plain read/write storage for a watchdog that is not built here.

Top module: `timer_bank`

## Requirements
- R1: After reset, the interrupt-enable and status registers read zero and every `irq_o` bit is low. Every channel reads control 0x04 (source 1, prescale exponent 0, stopped), interval 0 and count 0.
- R2: `irq_o[i]` is high exactly when status bit i and enable bit i are both set.
- R3: A write to the status register clears each bit written as 1 and keeps each bit written as 0. An expiry in the same cycle sets its bit, and the set wins over the clear.
- R4: The address map is as follows. Interrupt enable is at 0x000 and interrupt status is at 0x004. Channel i occupies 0x10*(i+1), with control at +0x0, interval at +0x4 and count at +0x8. Watchdog storage words are at 0x090 and 0x094. Any other address reads zero, and a write to it changes nothing. Read data appears on `reg_rdata` in the cycle after `reg_rd`, and the output is zero when no read was made.
- R5: The control word uses these fields: bit 0 is run, bit 1 is load-now, bits [3:2] are the source select, bits [6:4] are the prescale exponent n, and bit 7 is one-shot. Bits [7:0] read back as written, and bits [31:8] read zero.
- R6: A running channel takes one counting step for every 2^n ticks of its selected source. Ticks on the other sources have no effect. A control write restarts the prescale phase, so the first step then comes on the 2^n-th selected tick after the write.
- R7: A control write with bit 1 set copies the interval into the count. While bit 0 is clear, the count holds.
- R8: An interval write sets both the interval and the count to the written value.
- R9: A counting step taken at count zero sets the channel's status bit. In periodic mode (bit 7 clear), that step loads the count from the interval. Any other step decrements the count by one.
- R10: In one-shot mode, the expiring step clears control bit 0, so the channel then stops and reads back with bit 0 low.
- R11: A read of the count word returns the live counter. Writes to the count word are ignored.
- R12: A control or interval write to a channel takes priority over a tick for that channel in the same cycle. The tick is dropped and the prescale phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Single-cycle tick enables of the four count sources |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| irq_o | output | 6 | Per-channel interrupt lines |

## Verification
Several rules are checked by properties on every cycle:
- a step taken at a nonzero count decrements by one;
- a stopped channel's count stays put;
- a periodic expiry reloads the interval, and a one-shot expiry drops the run bit;
- an expiry always leaves its status bit set;
- an acknowledge with no competing expiry clears the written bits;
- an unmapped read returns zero.

Prescale phase, source isolation, the write-over-tick priority and the exact interrupt timing are shown only by the bench's scenarios. The bench compares every read and every `irq_o` value against its own model of the register file, under directed and random traffic.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  localparam int NUM_SRC = 4;
  localparam int EXP_W   = 3;

  typedef struct packed {
    logic             oneshot;
    logic [EXP_W-1:0] pre_exp;
    logic [1:0]       src_sel;
    logic             load_now;
    logic             run;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RST = '{oneshot: 1'b0, pre_exp: 3'd0, src_sel: 2'd1,
                                     load_now: 1'b0, run: 1'b0};

  localparam logic [9:0] OFS_IRQ_EN = 10'h000;
  localparam logic [9:0] OFS_IRQ_ST = 10'h004;
  localparam logic [9:0] OFS_WD_A   = 10'h090;
  localparam logic [9:0] OFS_WD_B   = 10'h094;

  localparam logic [3:0] SUB_CTRL = 4'h0;
  localparam logic [3:0] SUB_IVAL = 4'h4;
  localparam logic [3:0] SUB_CNT  = 4'h8;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             src_pulse,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << EXP_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, mask;

  always_comb begin
    mask   = (PC_W'(1) << exp_i) - PC_W'(1);
    tick_o = run & src_pulse & ((pc_q & mask) == mask);
    pc_d   = pc_q;
    if (restart)               pc_d = '0;
    else if (run && src_pulse) pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import timer_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               ctrl_we,
  input  logic               ival_we,
  input  tmr_ctrl_t          ctrl_wdata,
  input  logic [CNT_W-1:0]   ival_wdata,
  output tmr_ctrl_t          ctrl_o,
  output logic [CNT_W-1:0]   ival_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               expire_o
);
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] ival_q, ival_d, cnt_q, cnt_d;
  logic             busy, src_pulse, step;

  assign busy      = ctrl_we | ival_we;
  assign src_pulse = src_tick[ctrl_q.src_sel];

  tmr_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ctrl_we),
    .run       (ctrl_q.run & ~busy),
    .src_pulse (src_pulse),
    .exp_i     (ctrl_q.pre_exp),
    .tick_o    (step)
  );

  always_comb begin
    ctrl_d   = ctrl_q;
    ival_d   = ival_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (ctrl_we) begin
      ctrl_d = ctrl_wdata;
      if (ctrl_wdata.load_now) cnt_d = ival_q;
    end else if (ival_we) begin
      ival_d = ival_wdata;
      cnt_d  = ival_wdata;
    end else if (step) begin
      if (cnt_q == '0) begin
        expire_o = 1'b1;
        if (ctrl_q.oneshot) ctrl_d.run = 1'b0;
        else                cnt_d      = ival_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ival_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ival_q <= ival_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R9
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !ctrl_q.oneshot) |=> cnt_q == $past(ival_q));
  // R10
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && ctrl_q.oneshot) |=> !ctrl_q.run);
  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ctrl_we && !ival_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              st_we,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] expire_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] st_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] en_q, en_d, st_q, st_d;

  always_comb begin
    en_d = en_we ? wdata : en_q;
    st_d = (st_we ? (st_q & ~wdata) : st_q) | expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = st_q & en_q;

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && expire_i == '0) |=> (st_q & $past(wdata)) == '0);
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i != '0) |=> (st_q & $past(expire_i)) == $past(expire_i));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0]  irq_o
);
  localparam int CW = $bits(tmr_ctrl_t);

  logic              rst_s;
  logic              hi_zero;
  logic [3:0]        slot, sub;
  logic [NUM_CH-1:0] ch_sel, ctrl_we, ival_we, expire;
  logic [NUM_CH-1:0] irq_en, irq_st;
  tmr_ctrl_t         ctrl_arr [NUM_CH];
  logic [CNT_W-1:0]  ival_arr [NUM_CH];
  logic [CNT_W-1:0]  cnt_arr  [NUM_CH];
  logic [DATA_W-1:0] wd_a_q, wd_a_d, wd_b_q, wd_b_d;
  logic [DATA_W-1:0] rd_mux, rdata_d, rdata_q;
  logic              rd_hit, en_we, st_we;

  tmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_s));

  assign hi_zero = (reg_addr[ADDR_W-1:8] == '0);
  assign slot    = reg_addr[7:4];
  assign sub     = reg_addr[3:0];
  assign en_we   = reg_wr && reg_addr == ADDR_W'(OFS_IRQ_EN);
  assign st_we   = reg_wr && reg_addr == ADDR_W'(OFS_IRQ_ST);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_sel[g]  = hi_zero && slot == 4'(g + 1);
    assign ctrl_we[g] = reg_wr && ch_sel[g] && sub == SUB_CTRL;
    assign ival_we[g] = reg_wr && ch_sel[g] && sub == SUB_IVAL;

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_s),
      .src_tick   (src_tick),
      .ctrl_we    (ctrl_we[g]),
      .ival_we    (ival_we[g]),
      .ctrl_wdata (tmr_ctrl_t'(reg_wdata[CW-1:0])),
      .ival_wdata (reg_wdata[CNT_W-1:0]),
      .ctrl_o     (ctrl_arr[g]),
      .ival_o     (ival_arr[g]),
      .cnt_o      (cnt_arr[g]),
      .expire_o   (expire[g])
    );
  end

  tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_s),
    .en_we    (en_we),
    .st_we    (st_we),
    .wdata    (reg_wdata[NUM_CH-1:0]),
    .expire_i (expire),
    .en_o     (irq_en),
    .st_o     (irq_st),
    .irq_o    (irq_o)
  );

  always_comb begin
    wd_a_d = wd_a_q;
    wd_b_d = wd_b_q;
    if (reg_wr && reg_addr == ADDR_W'(OFS_WD_A)) wd_a_d = reg_wdata;
    if (reg_wr && reg_addr == ADDR_W'(OFS_WD_B)) wd_b_d = reg_wdata;
  end

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b0;
    if (reg_addr == ADDR_W'(OFS_IRQ_EN)) begin
      rd_mux = DATA_W'(irq_en); rd_hit = 1'b1;
    end else if (reg_addr == ADDR_W'(OFS_IRQ_ST)) begin
      rd_mux = DATA_W'(irq_st); rd_hit = 1'b1;
    end else if (reg_addr == ADDR_W'(OFS_WD_A)) begin
      rd_mux = wd_a_q; rd_hit = 1'b1;
    end else if (reg_addr == ADDR_W'(OFS_WD_B)) begin
      rd_mux = wd_b_q; rd_hit = 1'b1;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (sub)
          SUB_CTRL: begin rd_mux = DATA_W'(ctrl_arr[i]); rd_hit = 1'b1; end
          SUB_IVAL: begin rd_mux = DATA_W'(ival_arr[i]); rd_hit = 1'b1; end
          SUB_CNT:  begin rd_mux = DATA_W'(cnt_arr[i]);  rd_hit = 1'b1; end
          default:  ;
        endcase
      end
    end
    rdata_d = reg_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wd_a_q  <= '0;
      wd_b_q  <= '0;
      rdata_q <= '0;
    end else begin
      wd_a_q  <= wd_a_d;
      wd_b_q  <= wd_b_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_rd && !rd_hit) |=> reg_rdata == '0);
  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !reg_rd |=> reg_rdata == '0);
endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  irq_o;

  timer_bank dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  bit    chk_on = 1'b0, rd_pend = 1'b0;
  logic [31:0] exp_rd;

  logic [7:0]  m_ctrl [NCH];
  logic [31:0] m_ival [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [6:0]  m_pre  [NCH];
  logic [5:0]  m_en, m_st;
  logic [31:0] m_wda, m_wdb;

  function automatic logic [31:0] mread(input logic [9:0] a);
    int s;
    s = int'(a[7:4]);
    if (a == 10'h000) return {26'd0, m_en};
    if (a == 10'h004) return {26'd0, m_st};
    if (a == 10'h090) return m_wda;
    if (a == 10'h094) return m_wdb;
    if (a[9:8] == 2'b00 && s >= 1 && s <= NCH) begin
      case (a[3:0])
        4'h0: return {24'd0, m_ctrl[s-1]};
        4'h4: return m_ival[s-1];
        4'h8: return m_cnt[s-1];
        default: return 32'd0;
      endcase
    end
    return 32'd0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Reference model, advanced on each rising edge (the DUT's reset is synchronised, so
  // the model stays in reset until the bench has left a few idle cycles).
  always @(posedge clk) begin
    logic [5:0] set;
    logic [6:0] msk;
    bit         cw, iw;
    cycles++;
    if (cycles > WDOG_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cycles, WDOG_LIMIT);
      finish_run();
    end
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = 8'h04; m_ival[c] = 0; m_cnt[c] = 0; m_pre[c] = 0;
      end
      m_en = 0; m_st = 0; m_wda = 0; m_wdb = 0;
      rd_pend = 1'b0; chk_on = 1'b0;
    end else begin
      chk_on  = 1'b1;
      exp_rd  = reg_rd ? mread(reg_addr) : 32'd0;
      rd_pend = reg_rd;
      set = '0;
      for (int c = 0; c < NCH; c++) begin
        cw = reg_wr && reg_addr == 10'((c + 1) * 16);
        iw = reg_wr && reg_addr == 10'((c + 1) * 16 + 4);
        if (cw) begin
          m_ctrl[c] = reg_wdata[7:0];
          if (reg_wdata[1]) m_cnt[c] = m_ival[c];
          m_pre[c] = 0;
        end else if (iw) begin
          m_ival[c] = reg_wdata; m_cnt[c] = reg_wdata;
        end else if (m_ctrl[c][0] && src_tick[m_ctrl[c][3:2]]) begin
          msk = 7'((8'd1 << m_ctrl[c][6:4]) - 8'd1);
          if ((m_pre[c] & msk) == msk) begin
            if (m_cnt[c] == 0) begin
              set[c] = 1'b1;
              if (m_ctrl[c][7]) m_ctrl[c][0] = 1'b0;
              else              m_cnt[c] = m_ival[c];
            end else m_cnt[c] = m_cnt[c] - 1;
          end
          m_pre[c] = m_pre[c] + 7'd1;
        end
      end
      if (reg_wr && reg_addr == 10'h000) m_en = reg_wdata[5:0];
      if (reg_wr && reg_addr == 10'h004) m_st = m_st & ~reg_wdata[5:0];
      if (reg_wr && reg_addr == 10'h090) m_wda = reg_wdata;
      if (reg_wr && reg_addr == 10'h094) m_wdb = reg_wdata;
      m_st = m_st | set;
    end
  end

  // Output comparison away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      if (rd_pend) check(reg_rdata, exp_rd, cur_req);
      else         check(reg_rdata, 32'd0, "R4 idle read data");
      check({26'd0, irq_o}, {26'd0, m_st & m_en}, "R2 irq lines");
    end
  end

  task automatic cyc(input logic [3:0] t);
    reg_wr = 0; reg_rd = 0; src_tick = t;
    @(negedge clk);
  endtask
  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] t = 4'd0);
    reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d; src_tick = t;
    @(negedge clk);
  endtask
  task automatic rd(input logic [9:0] a, input logic [3:0] t = 4'd0);
    reg_wr = 0; reg_rd = 1; reg_addr = a; src_tick = t;
    @(negedge clk);
  endtask
  task automatic ticks(input int n, input logic [3:0] t);
    for (int i = 0; i < n; i++) cyc(t);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1 reset values";
    rd(10'h000); rd(10'h004);
    for (int c = 0; c < NCH; c++) begin
      rd(10'((c + 1) * 16)); rd(10'((c + 1) * 16 + 4)); rd(10'((c + 1) * 16 + 8));
    end

    cur_req = "R4 map and unmapped";
    wr(10'h090, 32'hA5A5_1234); wr(10'h094, 32'h0F0F_F0F0);
    rd(10'h090); rd(10'h094);
    wr(10'h3F0, 32'hFFFF_FFFF); wr(10'h01C, 32'h1234);
    rd(10'h3F0); rd(10'h01C); rd(10'h00C); rd(10'h070); rd(10'h110);

    cur_req = "R8 interval write";
    wr(10'h014, 32'd5); rd(10'h014); rd(10'h018);
    cur_req = "R11 count write ignored";
    wr(10'h018, 32'd99); rd(10'h018);

    cur_req = "R5 control readback";
    wr(10'h010, 32'hFFFF_FF00); rd(10'h010);
    cur_req = "R9 periodic count";
    wr(10'h000, 32'h3F);
    wr(10'h010, 32'h01);
    ticks(3, 4'b0001); rd(10'h018);
    cur_req = "R6 other sources ignored";
    ticks(4, 4'b1110); rd(10'h018);
    cur_req = "R7 stopped holds";
    wr(10'h010, 32'h00); ticks(3, 4'b0001); rd(10'h018);
    cur_req = "R7 load-now";
    wr(10'h010, 32'h02); rd(10'h018);

    cur_req = "R9 periodic expiry";
    wr(10'h014, 32'd2); wr(10'h010, 32'h01);
    ticks(3, 4'b0001); rd(10'h004); rd(10'h018);
    cur_req = "R3 zero write keeps";
    wr(10'h004, 32'h0); rd(10'h004);
    cur_req = "R3 one write clears";
    wr(10'h004, 32'h1); rd(10'h004);

    cur_req = "R10 one-shot";
    wr(10'h024, 32'd1); wr(10'h020, 32'h81);
    ticks(3, 4'b0001); rd(10'h020); rd(10'h004); ticks(3, 4'b0001); rd(10'h028);

    cur_req = "R6 prescale by four";
    wr(10'h034, 32'd20); wr(10'h030, 32'h29);
    ticks(3, 4'b0100); rd(10'h038);
    ticks(1, 4'b0100); rd(10'h038);
    ticks(8, 4'b1011); rd(10'h038);
    ticks(8, 4'b0100); rd(10'h038);

    cur_req = "R12 write over tick";
    wr(10'h044, 32'd9); wr(10'h040, 32'h01);
    wr(10'h044, 32'd7, 4'b0001); rd(10'h048);
    wr(10'h040, 32'h01, 4'b0001); rd(10'h048);

    cur_req = "R3 expiry beats clear";
    wr(10'h054, 32'd0); wr(10'h050, 32'h01);
    ticks(2, 4'b0001); wr(10'h004, 32'h3F, 4'b0001); rd(10'h004);

    cur_req = "R2 R6 R9 R10 R11 random";
    for (int k = 0; k < 4000; k++) begin
      int op, ch;
      logic [31:0] v;
      logic [3:0] t;
      op = int'($urandom % 16);
      ch = int'($urandom % NCH);
      t  = 4'($urandom);
      case (op)
        0, 1: begin
          v = $urandom & 32'hFF;
          v[6:4] = 3'($urandom % 3);
          v[0] = ($urandom % 4) != 0;
          wr(10'((ch + 1) * 16), v, t);
        end
        2: wr(10'((ch + 1) * 16 + 4), $urandom % 12, t);
        3: wr(10'h000, $urandom, t);
        4: wr(10'h004, $urandom, t);
        5, 6, 7, 8: rd(10'((ch + 1) * 16 + 4 * int'($urandom % 3)), t);
        9: rd(10'h004, t);
        10: rd(10'($urandom), t);
        11: wr(10'($urandom), $urandom, t);
        default: cyc(t);
      endcase
    end
    cyc(4'd0); cyc(4'd0);
    finish_run();
  end
endmodule